// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the 11-bit fetch address of a small 8-bit RISC core and picks the next one every instruction cycle. Each clock edge of the block stands for one whole instruction cycle, that is, all four internal clock phases. The fetch of one instruction overlaps the execution of the one before it. So `pc_o` is the address being fetched, and the instruction the decoder executes sits one word lower.

The decoder raises one-cycle strobes for its control flow:

- a taken skip;
- a write to the low address byte;
- a jump;
- a call;
- a return.

Two interrupt acknowledges force entry to fixed vectors. Calls and interrupt entries save the address being fetched on a four-level circular return stack, and returns take it back.

Every accepted change of flow raises `flush_o` for the next cycle. This marks the prefetched word as a dummy cycle, and the decoder must discard it. During that cycle the block ignores every strobe and acknowledge, and it simply steps forward.

Top module: `pcseq_top`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `pc_o` = 000h and `flush_o` = 1.
- R2: With `flush_o` low and no strobe or acknowledge, `pc_o` advances by one modulo 2048 (7FFh wraps to 000h), and `flush_o` is 0 next cycle.
- R3: While `flush_o` is high, all strobes and acknowledges are ignored: `pc_o` advances by one, nothing is pushed or popped, and `flush_o` falls.
- R4: A taken skip (`skip_i`) advances `pc_o` by one and sets `flush_o`, so the discarded word is passed over.
- R5: A low-byte write (`pcl_wr_i`) gives `pc_o` = {old `pc_o`[10:8], `pcl_data_i`} and sets `flush_o`.
- R6: A jump loads all 11 bits of `target_i` into `pc_o` and sets `flush_o`.
- R7: A call pushes the current `pc_o` as the return address, loads `target_i`, and sets `flush_o`.
- R8: A return loads `pc_o` from the top of the stack, pops it, and sets `flush_o`.
- R9: An external interrupt acknowledge pushes the current `pc_o`, loads 004h, and sets `flush_o`.
- R10: A timer acknowledge pushes `pc_o` and loads 008h. The external acknowledge wins when both are high. Either acknowledge overrides any decoder strobe in the same cycle.
- R11: The stack holds four return addresses. A fifth push overwrites the oldest entry without error, and pops wrap the same way.
- R12: Among decoder strobes raised together, the priority is return, then call, then jump, then low-byte write, then skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| skip_i | input | 1 | Conditional skip taken |
| pcl_wr_i | input | 1 | Write to the low address byte |
| pcl_data_i | input | 8 | Data for the low-byte write |
| jump_i | input | 1 | Unconditional jump |
| call_i | input | 1 | Subroutine call |
| ret_i | input | 1 | Return from subroutine or interrupt |
| target_i | input | 11 | Address field of jump or call |
| ext_ack_i | input | 1 | External interrupt acknowledge |
| tmr_ack_i | input | 1 | Timer overflow interrupt acknowledge |
| pc_o | output | 11 | Address being fetched |
| flush_o | output | 1 | Current fetched word is a dummy cycle |

## Verification
The bench builds the block with its default parameters:

- an 11-bit address;
- an 8-bit low byte;
- a four-entry stack;
- vectors 004h and 008h.

With only four entries, five nested calls are enough to reach stack wraparound, and the following returns show the overwritten slot. The 2K address space lets a single jump to 7FFh followed by one fetch show the modulo wrap. A low-byte write at 126h shows that the page bits are kept.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PCSEQ_PC_W    = 11;
    localparam int PCSEQ_LOW_W   = 8;
    localparam int PCSEQ_DEPTH   = 4;

    typedef enum logic [2:0] {
        SRC_SEQ,
        SRC_PCL,
        SRC_TGT,
        SRC_STACK,
        SRC_VEC_EXT,
        SRC_VEC_TMR
    } src_e;

    typedef struct packed {
        src_e src;
        logic push;
        logic pop;
        logic flush;
    } sel_t;

    function automatic sel_t sel_default();
        sel_t s;
        s.src   = SRC_SEQ;
        s.push  = 1'b0;
        s.pop   = 1'b0;
        s.flush = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic flush_i,
    input  logic skip_i,
    input  logic pcl_wr_i,
    input  logic jump_i,
    input  logic call_i,
    input  logic ret_i,
    input  logic ext_ack_i,
    input  logic tmr_ack_i,
    output sel_t sel_o
);

    always_comb begin
        sel_o = sel_default();
        if (!flush_i) begin
            if (ext_ack_i) begin
                sel_o.src   = SRC_VEC_EXT;
                sel_o.push  = 1'b1;
                sel_o.flush = 1'b1;
            end else if (tmr_ack_i) begin
                sel_o.src   = SRC_VEC_TMR;
                sel_o.push  = 1'b1;
                sel_o.flush = 1'b1;
            end else if (ret_i) begin
                sel_o.src   = SRC_STACK;
                sel_o.pop   = 1'b1;
                sel_o.flush = 1'b1;
            end else if (call_i) begin
                sel_o.src   = SRC_TGT;
                sel_o.push  = 1'b1;
                sel_o.flush = 1'b1;
            end else if (jump_i) begin
                sel_o.src   = SRC_TGT;
                sel_o.flush = 1'b1;
            end else if (pcl_wr_i) begin
                sel_o.src   = SRC_PCL;
                sel_o.flush = 1'b1;
            end else if (skip_i) begin
                sel_o.flush = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_dec;

    assign ptr_dec = ptr_q - PTR_W'(1);
    assign top_o   = slot_q[ptr_dec];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else if (push_i) begin
            slot_q[ptr_q] <= din_i;
            ptr_q         <= ptr_q + PTR_W'(1);
        end else if (pop_i) begin
            ptr_q <= ptr_dec;
        end
    end

endmodule

// File: rtl/pcseq_nextpc.sv
module pcseq_nextpc
    import pcseq_pkg::*;
#(
    parameter int PC_W    = 11,
    parameter int LOW_W   = 8,
    parameter int EXT_VEC = 4,
    parameter int TMR_VEC = 8
) (
    input  src_e              src_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [PC_W-1:0]   stack_top_i,
    input  logic [LOW_W-1:0]  low_i,
    output logic [PC_W-1:0]   next_o
);

    localparam int PAGE_W = PC_W - LOW_W;

    logic [PC_W-1:0] page_jump;

    generate
        if (PAGE_W > 0) begin : g_paged
            assign page_jump = {pc_i[PC_W-1:LOW_W], low_i};
        end else begin : g_flat
            assign page_jump = low_i[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (src_i)
            SRC_PCL:     next_o = page_jump;
            SRC_TGT:     next_o = target_i;
            SRC_STACK:   next_o = stack_top_i;
            SRC_VEC_EXT: next_o = PC_W'(EXT_VEC);
            SRC_VEC_TMR: next_o = PC_W'(TMR_VEC);
            default:     next_o = pc_i + PC_W'(1);
        endcase
    end

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W      = PCSEQ_PC_W,
    parameter int LOW_W     = PCSEQ_LOW_W,
    parameter int DEPTH     = PCSEQ_DEPTH,
    parameter int RESET_VEC = 0,
    parameter int EXT_VEC   = 4,
    parameter int TMR_VEC   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             skip_i,
    input  logic             pcl_wr_i,
    input  logic [LOW_W-1:0] pcl_data_i,
    input  logic             jump_i,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic             ext_ack_i,
    input  logic             tmr_ack_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             flush_o
);

    logic [PC_W-1:0] pc_q;
    logic            flush_q;
    logic [PC_W-1:0] pc_next;
    logic [PC_W-1:0] stack_top;
    sel_t            sel;

    pcseq_arbiter u_arb (
        .flush_i   (flush_q),
        .skip_i    (skip_i),
        .pcl_wr_i  (pcl_wr_i),
        .jump_i    (jump_i),
        .call_i    (call_i),
        .ret_i     (ret_i),
        .ext_ack_i (ext_ack_i),
        .tmr_ack_i (tmr_ack_i),
        .sel_o     (sel)
    );

    pcseq_stack #(
        .W     (PC_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk    (clk),
        .rst    (rst),
        .push_i (sel.push),
        .pop_i  (sel.pop),
        .din_i  (pc_q),
        .top_o  (stack_top)
    );

    pcseq_nextpc #(
        .PC_W    (PC_W),
        .LOW_W   (LOW_W),
        .EXT_VEC (EXT_VEC),
        .TMR_VEC (TMR_VEC)
    ) u_next (
        .src_i       (sel.src),
        .pc_i        (pc_q),
        .target_i    (target_i),
        .stack_top_i (stack_top),
        .low_i       (pcl_data_i),
        .next_o      (pc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= PC_W'(RESET_VEC);
            flush_q <= 1'b1;
        end else begin
            pc_q    <= pc_next;
            flush_q <= sel.flush;
        end
    end

    assign pc_o    = pc_q;
    assign flush_o = flush_q;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
    parameter int PC_W      = 11,
    parameter int LOW_W     = 8,
    parameter int RESET_VEC = 0,
    parameter int EXT_VEC   = 4,
    parameter int TMR_VEC   = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             skip_i,
    input logic             pcl_wr_i,
    input logic [LOW_W-1:0] pcl_data_i,
    input logic             jump_i,
    input logic             call_i,
    input logic             ret_i,
    input logic [PC_W-1:0]  target_i,
    input logic             ext_ack_i,
    input logic             tmr_ack_i,
    input logic [PC_W-1:0]  pc_o,
    input logic             flush_o
);

    logic any_req;
    assign any_req = skip_i | pcl_wr_i | jump_i | call_i | ret_i | ext_ack_i | tmr_ack_i;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pc_o == PC_W'(RESET_VEC)) && flush_o);

    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && !any_req) |=> (pc_o == $past(pc_o) + PC_W'(1)) && !flush_o);

    a_r3_flush_ignores: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> (pc_o == $past(pc_o) + PC_W'(1)) && !flush_o);

    a_r4_skip_flush: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && skip_i) |=> flush_o);

    a_r5_page_kept: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && pcl_wr_i && !jump_i && !call_i && !ret_i && !ext_ack_i && !tmr_ack_i)
        |=> (pc_o[PC_W-1:LOW_W] == $past(pc_o[PC_W-1:LOW_W]))
            && (pc_o[LOW_W-1:0] == $past(pcl_data_i)));

    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && jump_i && !call_i && !ret_i && !ext_ack_i && !tmr_ack_i)
        |=> (pc_o == $past(target_i)) && flush_o);

    a_r9_ext_vector: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && ext_ack_i) |=> (pc_o == PC_W'(EXT_VEC)) && flush_o);

    a_r10_tmr_vector: assert property (@(posedge clk) disable iff (rst)
        (!flush_o && tmr_ack_i && !ext_ack_i) |=> (pc_o == PC_W'(TMR_VEC)) && flush_o);

endmodule

bind pcseq_top pcseq_chk #(
    .PC_W      (PC_W),
    .LOW_W     (LOW_W),
    .RESET_VEC (RESET_VEC),
    .EXT_VEC   (EXT_VEC),
    .TMR_VEC   (TMR_VEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .skip_i     (skip_i),
    .pcl_wr_i   (pcl_wr_i),
    .pcl_data_i (pcl_data_i),
    .jump_i     (jump_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .target_i   (target_i),
    .ext_ack_i  (ext_ack_i),
    .tmr_ack_i  (tmr_ack_i),
    .pc_o       (pc_o),
    .flush_o    (flush_o)
);

// File: tb/tb_pcseq_top.sv
module tb_pcseq_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        skip_i, pcl_wr_i, jump_i, call_i, ret_i, ext_ack_i, tmr_ack_i;
    logic [7:0]  pcl_data_i;
    logic [10:0] target_i;
    logic [10:0] pc_o;
    logic        flush_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pcseq_top dut (
        .clk        (clk),
        .rst        (rst),
        .skip_i     (skip_i),
        .pcl_wr_i   (pcl_wr_i),
        .pcl_data_i (pcl_data_i),
        .jump_i     (jump_i),
        .call_i     (call_i),
        .ret_i      (ret_i),
        .target_i   (target_i),
        .ext_ack_i  (ext_ack_i),
        .tmr_ack_i  (tmr_ack_i),
        .pc_o       (pc_o),
        .flush_o    (flush_o)
    );

    // control bits: {ret, call, jump, pcl_wr, skip, ext, tmr}
    localparam logic [6:0] N  = 7'b0000000;
    localparam logic [6:0] RT = 7'b1000000;
    localparam logic [6:0] CL = 7'b0100000;
    localparam logic [6:0] JP = 7'b0010000;
    localparam logic [6:0] PW = 7'b0001000;
    localparam logic [6:0] SK = 7'b0000100;
    localparam logic [6:0] EX = 7'b0000010;
    localparam logic [6:0] TM = 7'b0000001;

    typedef struct packed {
        logic [6:0]  ctl;
        logic [10:0] tgt;
        logic [7:0]  dat;
        logic [10:0] epc;
        logic        efl;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 52;
    localparam vec_t TBL [NV] = '{
        '{N,     11'h000, 8'h00, 11'h001, 1'b0, 4'd3},  // R3 dummy after reset
        '{N,     11'h000, 8'h00, 11'h002, 1'b0, 4'd2},  // R2
        '{JP,    11'h123, 8'h00, 11'h123, 1'b1, 4'd6},  // R6
        '{CL,    11'h500, 8'h00, 11'h124, 1'b0, 4'd3},  // R3 call ignored
        '{CL,    11'h500, 8'h00, 11'h500, 1'b1, 4'd7},  // R7 push 124
        '{N,     11'h000, 8'h00, 11'h501, 1'b0, 4'd2},
        '{SK,    11'h000, 8'h00, 11'h502, 1'b1, 4'd4},  // R4
        '{N,     11'h000, 8'h00, 11'h503, 1'b0, 4'd4},
        '{PW,    11'h000, 8'h10, 11'h510, 1'b1, 4'd5},  // R5
        '{N,     11'h000, 8'h00, 11'h511, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h124, 1'b1, 4'd8},  // R8
        '{N,     11'h000, 8'h00, 11'h125, 1'b0, 4'd2},
        '{EX|TM, 11'h000, 8'h00, 11'h004, 1'b1, 4'd10}, // R10 ext wins
        '{N,     11'h000, 8'h00, 11'h005, 1'b0, 4'd2},
        '{TM,    11'h000, 8'h00, 11'h008, 1'b1, 4'd10}, // R10 timer vector
        '{N,     11'h000, 8'h00, 11'h009, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h005, 1'b1, 4'd8},
        '{N,     11'h000, 8'h00, 11'h006, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h125, 1'b1, 4'd9},  // R9 return address
        '{N,     11'h000, 8'h00, 11'h126, 1'b0, 4'd2},
        '{PW,    11'h000, 8'hFF, 11'h1FF, 1'b1, 4'd5},  // R5 page kept
        '{N,     11'h000, 8'h00, 11'h200, 1'b0, 4'd2},
        '{JP,    11'h7FF, 8'h00, 11'h7FF, 1'b1, 4'd6},
        '{N,     11'h000, 8'h00, 11'h000, 1'b0, 4'd2},  // R2 wrap
        '{CL,    11'h010, 8'h00, 11'h010, 1'b1, 4'd11}, // R11 nest 1
        '{N,     11'h000, 8'h00, 11'h011, 1'b0, 4'd2},
        '{CL,    11'h020, 8'h00, 11'h020, 1'b1, 4'd11},
        '{N,     11'h000, 8'h00, 11'h021, 1'b0, 4'd2},
        '{CL,    11'h030, 8'h00, 11'h030, 1'b1, 4'd11},
        '{N,     11'h000, 8'h00, 11'h031, 1'b0, 4'd2},
        '{CL,    11'h040, 8'h00, 11'h040, 1'b1, 4'd11},
        '{N,     11'h000, 8'h00, 11'h041, 1'b0, 4'd2},
        '{CL,    11'h050, 8'h00, 11'h050, 1'b1, 4'd11}, // fifth push
        '{N,     11'h000, 8'h00, 11'h051, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h041, 1'b1, 4'd11},
        '{N,     11'h000, 8'h00, 11'h042, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h031, 1'b1, 4'd11},
        '{N,     11'h000, 8'h00, 11'h032, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h021, 1'b1, 4'd11},
        '{N,     11'h000, 8'h00, 11'h022, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h011, 1'b1, 4'd11},
        '{N,     11'h000, 8'h00, 11'h012, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h041, 1'b1, 4'd11}, // R11 oldest overwritten
        '{N,     11'h000, 8'h00, 11'h042, 1'b0, 4'd2},
        '{JP,    11'h300, 8'h00, 11'h300, 1'b1, 4'd6},
        '{EX,    11'h000, 8'h00, 11'h301, 1'b0, 4'd3},  // R3 ack ignored
        '{JP|SK, 11'h0AA, 8'h00, 11'h0AA, 1'b1, 4'd12}, // R12 jump over skip
        '{N,     11'h000, 8'h00, 11'h0AB, 1'b0, 4'd2},
        '{EX|JP, 11'h333, 8'h00, 11'h004, 1'b1, 4'd10}, // R10 ack over strobe
        '{N,     11'h000, 8'h00, 11'h005, 1'b0, 4'd2},
        '{RT,    11'h000, 8'h00, 11'h0AB, 1'b1, 4'd9},  // R9
        '{N,     11'h000, 8'h00, 11'h0AC, 1'b0, 4'd2}
    };

    task automatic drive(input logic [6:0] c, input logic [10:0] t, input logic [7:0] d);
        {ret_i, call_i, jump_i, pcl_wr_i, skip_i, ext_ack_i, tmr_ack_i} = c;
        target_i   = t;
        pcl_data_i = d;
    endtask

    task automatic check(input int req, input logic [10:0] epc, input logic efl);
        checks++;
        if (pc_o !== epc || flush_o !== efl) begin
            errors++;
            $display("FAIL R%0d: pc=%03h flush=%0b expected pc=%03h flush=%0b",
                     req, pc_o, flush_o, epc, efl);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(N, 11'h0, 8'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1, 11'h000, 1'b1); // R1 reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].ctl, TBL[i].tgt, TBL[i].dat);
            @(posedge clk);
            @(negedge clk);
            check(int'(TBL[i].req), TBL[i].epc, TBL[i].efl);
        end

        // R1: reset overrides a call in the same cycle
        drive(CL, 11'h777, 8'h00);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(1, 11'h000, 1'b1);
        drive(N, 11'h0, 8'h0);
        @(posedge clk);
        @(negedge clk);
        check(1, 11'h000, 1'b1);
        rst = 1'b0;
        // R3: jump during the dummy cycle after reset is ignored
        drive(JP, 11'h2AA, 8'h00);
        @(posedge clk);
        @(negedge clk);
        check(3, 11'h001, 1'b0);
        // R12: return beats call; stack empty after reset reads slot 3 = 000h
        drive(RT | CL, 11'h444, 8'h00);
        @(posedge clk);
        @(negedge clk);
        check(12, 11'h000, 1'b1);
        drive(N, 11'h0, 8'h0);
        @(posedge clk);
        @(negedge clk);
        check(2, 11'h001, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule